// File: doc/BRIEF.md
# Three-Level T-Type Leg Commutation Sequencer

This block controls one leg of a three-level T-type inverter. The leg has four switches. Q1 connects the output to the positive rail and Q2 connects it to the negative rail. Q3 and Q4 are a back-to-back pair that connect the output to the DC-link midpoint. A controller asks for one of three output levels: positive rail, neutral or negative rail. The block maps that level onto the four gate enables. Each change of level is carried out as a fixed break-before-make order, with a dead-time gap between the steps. The gap is set in clock cycles. The order does not depend on the sign of the load current, so the block has no current-direction input.

A jump from one rail straight to the other is done as two steps through neutral, and each step has its own gap. Busy stays high until the final level is applied, and requests are dropped while it is high. A fault input turns every gate off in the same cycle and holds the leg off until a clear pulse. After the clear, the leg starts from all-off and must enter neutral again before it can reach a rail. A three-phase stage uses three instances.

Top module: `tleg_seq`

## Requirements
- R1: The applied level is reported on `level_out` as 0 = neutral, 1 = positive rail, 2 = negative rail, 3 = all off. With gates written {Q1,Q2,Q3,Q4}, the level codes give these gate patterns when the block is idle:
  - code 1 (positive rail): 1010
  - code 0 (neutral): 0011
  - code 2 (negative rail): 0101
  - code 3 (all off): 0000
- R2: Moving between positive rail and neutral uses Q3 alone for the gap. When leaving the rail, Q1 turns off first and Q4 turns on after the gap. When entering the rail, Q4 turns off first and Q1 turns on after the gap. Q3 stays on throughout.
- R3: Moving between neutral and negative rail uses Q4 alone for the gap. When entering the rail, Q3 turns off first and Q2 turns on after the gap. When leaving the rail, Q2 turns off first and Q3 turns on after the gap. Q4 stays on throughout.
- R4: The intermediate pattern lasts exactly `dt_cfg` cycles. A value of 0 counts as 1. The value is sampled when the request is accepted.
- R5: A request from one rail to the other runs as follows:
  - a first gap,
  - one cycle at the neutral pattern,
  - a second gap,
  - the final pattern.

  Busy stays high until the final pattern is applied.
- R6: The following requests leave the gates, `busy` and `level_out` unchanged:
  - any request made while busy,
  - a request for code 3,
  - a request for the level already applied.
- R7: Outside fault shutdown, Q3 and Q4 never change state in the same cycle.
- R8: Q1 and Q2 are never on together. Q1 is never on with Q4, and Q2 is never on with Q3.
- R9: While `fault` is high, all four gates are off in the same cycle. The leg then stays off with `faulted` high, and ignores requests, until `fault_clr` is pulsed.
- R10: After a clear, `level_out` reads 3 and all gates are off. The next accepted request first enters neutral by turning on Q3 alone, then Q4 after the gap.
- R11: After reset, all gates are off, `busy` and `faulted` are low, and `level_out` reads 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request strobe |
| req_level | input | 2 | Requested level code (see R1) |
| dt_cfg | input | DT_W | Dead-time gap in cycles |
| fault | input | 1 | Shutdown request, acts in the same cycle |
| fault_clr | input | 1 | Clears the latched shutdown |
| gate_q1 | output | 1 | Positive-rail switch enable |
| gate_q2 | output | 1 | Negative-rail switch enable |
| gate_q3 | output | 1 | Neutral switch, positive side |
| gate_q4 | output | 1 | Neutral switch, negative side |
| busy | output | 1 | Transition in progress |
| level_out | output | 2 | Last fully applied level code |
| faulted | output | 1 | Latched shutdown state |

## Verification
The assertions check the safety rules on every cycle:
- the forbidden gate combinations (R8),
- that Q3 and Q4 never change together (R7),
- that a fault means all gates are off (R9),
- the switch edges around Q1 and Q2 (R2, R3).

Other behaviours are only visible through the bench's scenarios:
- the length of each gap,
- the single neutral cycle in a rail-to-rail move,
- that requests are dropped,
- the restart order after a clear.

Each of these is shown by a traced cycle-by-cycle gate sequence compared with a path that the bench works out itself.

// File: rtl/tleg_pkg.sv
package tleg_pkg;

    typedef enum logic [1:0] {
        LV_NEU = 2'd0,
        LV_POS = 2'd1,
        LV_NEG = 2'd2,
        LV_OFF = 2'd3
    } lvl_e;

    // hi = Q1, lo = Q2, nh = Q3, nl = Q4
    typedef struct packed {
        logic hi;
        logic lo;
        logic nh;
        logic nl;
    } gate_t;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_GAP   = 2'd1,
        ST_STEP  = 2'd2,
        ST_FAULT = 2'd3
    } st_e;

    function automatic gate_t gates_of(input lvl_e l);
        gate_t g;
        g = '0;
        case (l)
            LV_POS:  begin g.hi = 1'b1; g.nh = 1'b1; end
            LV_NEU:  begin g.nh = 1'b1; g.nl = 1'b1; end
            LV_NEG:  begin g.lo = 1'b1; g.nl = 1'b1; end
            default: g = '0;
        endcase
        return g;
    endfunction

    // One step toward the target: every move passes through neutral.
    function automatic lvl_e next_of(input lvl_e cur, input lvl_e tgt);
        return (cur == LV_NEU) ? tgt : LV_NEU;
    endfunction

    // Pattern held during the gap: one neutral switch alone.
    function automatic gate_t mid_of(input lvl_e cur, input lvl_e nxt);
        gate_t g;
        g = '0;
        if (cur == LV_NEG || nxt == LV_NEG) g.nl = 1'b1;
        else                                g.nh = 1'b1;
        return g;
    endfunction

endpackage

// File: rtl/tleg_step_plan.sv
module tleg_step_plan
    import tleg_pkg::*;
(
    input  lvl_e  cur,
    input  lvl_e  tgt,
    output lvl_e  nxt,
    output gate_t mid,
    output gate_t fin
);
    always_comb begin
        nxt = next_of(cur, tgt);
        mid = mid_of(cur, nxt);
        fin = gates_of(nxt);
    end
endmodule

// File: rtl/tleg_dt_timer.sv
module tleg_dt_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         expired
);
    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clr)               cnt_d = '0;
        else if (load)         cnt_d = load_val;
        else if (cnt_q != '0)  cnt_d = cnt_q - W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign expired = (cnt_q == W'(1));
endmodule

// File: rtl/tleg_seq.sv
module tleg_seq
    import tleg_pkg::*;
#(
    parameter int DT_W = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            req_valid,
    input  logic [1:0]      req_level,
    input  logic [DT_W-1:0] dt_cfg,
    input  logic            fault,
    input  logic            fault_clr,
    output logic            gate_q1,
    output logic            gate_q2,
    output logic            gate_q3,
    output logic            gate_q4,
    output logic            busy,
    output logic [1:0]      level_out,
    output logic            faulted
);
    localparam logic [DT_W-1:0] DT_MIN = DT_W'(1);

    typedef struct packed {
        st_e             st;
        gate_t           g;
        lvl_e            lvl;
        lvl_e            tgt;
        logic [DT_W-1:0] dt;
    } regs_t;

    regs_t r_d, r_q;

    lvl_e            req_lvl, plan_tgt, plan_nxt;
    gate_t           plan_mid, plan_fin;
    logic [DT_W-1:0] dt_eff, t_val;
    logic            t_load, t_clr, t_exp;

    assign req_lvl  = lvl_e'(req_level);
    assign plan_tgt = (r_q.st == ST_IDLE) ? req_lvl : r_q.tgt;
    assign dt_eff   = (dt_cfg == '0) ? DT_MIN : dt_cfg;

    tleg_step_plan u_plan (
        .cur (r_q.lvl),
        .tgt (plan_tgt),
        .nxt (plan_nxt),
        .mid (plan_mid),
        .fin (plan_fin)
    );

    tleg_dt_timer #(.W(DT_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (t_clr),
        .load     (t_load),
        .load_val (t_val),
        .expired  (t_exp)
    );

    always_comb begin
        r_d    = r_q;
        t_load = 1'b0;
        t_clr  = 1'b0;
        t_val  = r_q.dt;
        case (r_q.st)
            ST_IDLE: begin
                if (req_valid && req_lvl != LV_OFF && req_lvl != r_q.lvl) begin
                    r_d.tgt = req_lvl;
                    r_d.dt  = dt_eff;
                    r_d.g   = plan_mid;
                    r_d.st  = ST_GAP;
                    t_load  = 1'b1;
                    t_val   = dt_eff;
                end
            end
            ST_GAP: begin
                if (t_exp) begin
                    r_d.g   = plan_fin;
                    r_d.lvl = plan_nxt;
                    r_d.st  = (plan_nxt == r_q.tgt) ? ST_IDLE : ST_STEP;
                end
            end
            ST_STEP: begin
                r_d.g  = plan_mid;
                r_d.st = ST_GAP;
                t_load = 1'b1;
            end
            ST_FAULT: begin
                if (fault_clr) r_d.st = ST_IDLE;
            end
            default: begin
                r_d.st  = ST_FAULT;
                r_d.g   = '0;
                r_d.lvl = LV_OFF;
            end
        endcase
        if (fault) begin
            r_d.st  = ST_FAULT;
            r_d.g   = '0;
            r_d.lvl = LV_OFF;
            t_clr   = 1'b1;
            t_load  = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.st  <= ST_IDLE;
            r_q.g   <= '0;
            r_q.lvl <= LV_OFF;
            r_q.tgt <= LV_OFF;
            r_q.dt  <= DT_MIN;
        end else begin
            r_q <= r_d;
        end
    end

    gate_t g_out;
    assign g_out     = fault ? gate_t'('0) : r_q.g;
    assign gate_q1   = g_out.hi;
    assign gate_q2   = g_out.lo;
    assign gate_q3   = g_out.nh;
    assign gate_q4   = g_out.nl;
    assign busy      = (r_q.st == ST_GAP) || (r_q.st == ST_STEP);
    assign level_out = r_q.lvl;
    assign faulted   = (r_q.st == ST_FAULT);
endmodule

// File: rtl/tleg_seq_chk.sv
module tleg_seq_chk (
    input logic clk,
    input logic rst_n,
    input logic fault,
    input logic faulted,
    input logic gate_q1,
    input logic gate_q2,
    input logic gate_q3,
    input logic gate_q4
);
    // R8
    no_shoot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(gate_q1 && gate_q2) && !(gate_q1 && gate_q4) && !(gate_q2 && gate_q3));

    // R7
    inner_pair_chk: assert property (@(posedge clk) disable iff (!rst_n || fault || faulted)
        !((gate_q3 != $past(gate_q3)) && (gate_q4 != $past(gate_q4))));

    // R9
    fault_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fault || faulted) |-> !(gate_q1 || gate_q2 || gate_q3 || gate_q4));

    // R2
    pos_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(gate_q1) |-> (gate_q3 && !gate_q4));

    // R2
    pos_exit_chk: assert property (@(posedge clk) disable iff (!rst_n || fault || faulted)
        $fell(gate_q1) |-> (gate_q3 && !gate_q4));

    // R3
    neg_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(gate_q2) |-> (gate_q4 && !gate_q3));
endmodule

bind tleg_seq tleg_seq_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .fault   (fault),
    .faulted (faulted),
    .gate_q1 (gate_q1),
    .gate_q2 (gate_q2),
    .gate_q3 (gate_q3),
    .gate_q4 (gate_q4)
);

// File: tb/sim_tleg_seq.sv
`timescale 1ns/1ps
module sim_tleg_seq;
    localparam int DT_W = 8;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            req_valid = 1'b0;
    logic [1:0]      req_level = 2'd0;
    logic [DT_W-1:0] dt_cfg = '0;
    logic            fault = 1'b0;
    logic            fault_clr = 1'b0;
    logic            gate_q1, gate_q2, gate_q3, gate_q4, busy, faulted;
    logic [1:0]      level_out;

    int n_chk = 0;
    int n_fail = 0;
    int v7 = 0;
    int v8 = 0;
    logic [1:0] cur = 2'd3;
    logic [3:0] prev_g = 4'd0;

    always #4 clk = ~clk;

    tleg_seq #(.DT_W(DT_W)) u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_level(req_level),
        .dt_cfg(dt_cfg), .fault(fault), .fault_clr(fault_clr),
        .gate_q1(gate_q1), .gate_q2(gate_q2), .gate_q3(gate_q3), .gate_q4(gate_q4),
        .busy(busy), .level_out(level_out), .faulted(faulted)
    );

    wire [3:0] g = {gate_q1, gate_q2, gate_q3, gate_q4};

    function automatic logic [3:0] pat_of(input logic [1:0] l);
        case (l)
            2'd1:    return 4'b1010;
            2'd0:    return 4'b0011;
            2'd2:    return 4'b0101;
            default: return 4'b0000;
        endcase
    endfunction

    function automatic logic [3:0] gap_of(input logic [1:0] a, input logic [1:0] b);
        return (a == 2'd2 || b == 2'd2) ? 4'b0001 : 4'b0010;
    endfunction

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // R7 / R8 monitor, sampled away from the active edge
    always @(negedge clk) begin
        if (rst_n && !fault && !faulted) begin
            if ((g[3] && g[2]) || (g[3] && g[0]) || (g[2] && g[1])) v8++;
            if ((g[1] != prev_g[1]) && (g[0] != prev_g[0])) v7++;
        end
        prev_g = g;
    end

    // Issue one request and trace the gates cycle by cycle.
    task automatic run_req(input logic [1:0] tgt, input int dt, input bit poke);
        int n;
        logic [1:0] c, nx;
        bit first;
        n = (dt == 0) ? 1 : dt;
        req_valid = 1'b1; req_level = tgt; dt_cfg = DT_W'(dt);
        @(posedge clk); @(negedge clk);
        req_valid = 1'b0;
        if (tgt == 2'd3 || tgt == cur) begin
            // R6: ignored request
            chk(busy == 1'b0, "R6 busy", busy, 0);
            chk(g == pat_of(cur), "R6 gates", g, pat_of(cur));
            chk(level_out == cur, "R6 level", level_out, cur);
            return;
        end
        c = cur; first = 1'b1;
        while (c != tgt) begin
            nx = (c == 2'd0) ? tgt : 2'd0;
            if (!first) begin
                // R5: one neutral cycle between the two steps
                chk(g == pat_of(2'd0) && busy, "R5 neutral hold", {busy, g}, {1'b1, pat_of(2'd0)});
                @(negedge clk);
            end
            for (int k = 0; k < n; k++) begin
                // R2 R3 R4 R10: gap pattern for exactly n cycles
                chk(g == gap_of(c, nx) && busy, "R4 gap", {busy, g}, {1'b1, gap_of(c, nx)});
                if (poke && first && k == 0) begin
                    req_valid = 1'b1;
                    req_level = (tgt == 2'd1) ? 2'd2 : 2'd1;
                    dt_cfg = 8'd9;
                end
                @(negedge clk);
                req_valid = 1'b0;
            end
            c = nx; first = 1'b0;
        end
        // R1: final pattern, busy released
        chk(g == pat_of(tgt) && !busy, "R1 final", {busy, g}, {1'b0, pat_of(tgt)});
        chk(level_out == tgt, "R1 level", level_out, tgt);
        cur = tgt;
    endtask

    initial begin
        #(8 * 200000);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        void'($urandom(32'd2718));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11: reset state
        chk(g == 4'd0, "R11 gates", g, 0);
        chk(!busy && !faulted, "R11 flags", {busy, faulted}, 0);
        chk(level_out == 2'd3, "R11 level", level_out, 3);

        run_req(2'd0, 3, 0);   // R10 entry from off
        run_req(2'd1, 2, 0);   // R2
        run_req(2'd0, 1, 0);   // R2
        run_req(2'd2, 4, 0);   // R3
        run_req(2'd0, 0, 0);   // R3, R4 zero gap
        run_req(2'd2, 2, 0);
        run_req(2'd1, 3, 0);   // R5 rail to rail
        run_req(2'd2, 1, 1);   // R5 + R6 request while busy
        run_req(2'd3, 2, 0);   // R6 invalid code
        run_req(2'd2, 2, 0);   // R6 same level

        // R9: fault during a gap
        run_req(2'd0, 1, 0);
        req_valid = 1'b1; req_level = 2'd1; dt_cfg = 8'd4;
        @(posedge clk); @(negedge clk);
        req_valid = 1'b0;
        fault = 1'b1;
        #1;
        chk(g == 4'd0, "R9 same cycle off", g, 0);
        @(negedge clk);
        fault = 1'b0;
        #1;
        chk(g == 4'd0 && faulted && !busy, "R9 latched", {faulted, busy, g}, 6'b100000);
        chk(level_out == 2'd3, "R9 level", level_out, 3);
        req_valid = 1'b1; req_level = 2'd0; dt_cfg = 8'd1;
        @(posedge clk); @(negedge clk);
        req_valid = 1'b0;
        @(negedge clk);
        chk(g == 4'd0 && faulted && !busy, "R9 request ignored", {faulted, busy, g}, 6'b100000);
        fault_clr = 1'b1;
        @(negedge clk);
        fault_clr = 1'b0;
        chk(!faulted && g == 4'd0, "R10 cleared", {faulted, g}, 0);
        chk(level_out == 2'd3, "R10 level", level_out, 3);
        cur = 2'd3;
        run_req(2'd1, 2, 0);   // R10: Q3 alone, neutral, Q3 alone, positive rail

        for (int i = 0; i < 40; i++) begin
            run_req(2'($urandom % 4), int'($urandom % 6), 1'($urandom % 2));
        end

        chk(v7 == 0, "R7 inner pair changes", v7, 0);
        chk(v8 == 0, "R8 forbidden pattern", v8, 0);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule